// File: doc/BRIEF.md
# Two-Clock Mailbox Bypass

This block holds one message register in each direction between two ports on unrelated clocks. It lets short control words pass between the ports without going through the data queues. Port A stores a word for port B in the forward slot, and port B stores a word for port A in the return slot. Each slot accepts one word, then refuses further writes until the far side has read it. The read returns the right to write to the sender. The write and read events cross the clock boundary as toggles through two-flop synchronizers.

Each slot has an active-low full flag in the writer's clock domain and an active-high ready flag in the reader's clock domain. Each port also has a registered read output. A per-port select chooses whether that output carries the slot contents or the queue data supplied from outside.

The slot width equals the port B width `BW`. Port A is `DW` bits wide. A slot keeps only the low `BW` bits of a port A word. When port A reads a slot, the bits above `BW` are zero.

Top module: `dual_mailbox`

## Requirements
- R1: While a domain's reset is high, and once reset is released in both domains, both full flags read 1 and both ready flags read 0. Both read outputs are all zero during reset.
- R2: A port A transfer with `a_wnr`=1 and `a_mbx`=1, while `mbx1_full_n`=1, stores `a_din[BW-1:0]` in the forward slot. `mbx1_full_n` reads 0 after that same edge.
- R3: A slot write is ignored while that slot's full flag is 0, and the stored word is unchanged.
- R4: A port B transfer with `b_rnw`=1 and `b_mbx`=1, while `mbx1_ready_b`=1, drops `mbx1_ready_b` after that edge. `mbx1_full_n` then returns to 1 within 4 port A clocks.
- R5: The return slot mirrors R2 to R4 with the ports swapped. A port B write (`b_rnw`=0, `b_mbx`=1) stores `b_din` and drops `mbx2_full_n`. A port A read (`a_wnr`=0, `a_mbx`=1) drops `mbx2_ready_a`, and `mbx2_full_n` returns to 1 within 4 port B clocks.
- R6: A port transfers only on a clock edge where its chip select is low and its enable is high. Any other edge has no effect on either slot's flags or contents.
- R7: One clock after each edge, a port's read output shows the slot contents if the select was 1 at that edge, and the outside queue data if it was 0. On port A, bits above `BW` are zero.
- R8: After a write is accepted, the reader's ready flag rises within 4 reader clocks.
- R9: A read with the select at 0, or a read while the ready flag is 0, leaves the ready and full flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Synchronous active-high reset, port A domain |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_en | input | 1 | Port A transfer enable |
| a_wnr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbx | input | 1 | Port A selects a mailbox slot |
| a_din | input | DW | Port A write data |
| a_fifo_q | input | DW | Queue data offered to port A |
| a_dout | output | DW | Port A registered read data |
| mbx1_full_n | output | 1 | Forward slot full, active low, port A clock |
| mbx2_ready_a | output | 1 | Return slot holds unread mail, port A clock |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Synchronous active-high reset, port B domain |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_en | input | 1 | Port B transfer enable |
| b_rnw | input | 1 | Port B direction: 1 read, 0 write |
| b_mbx | input | 1 | Port B selects a mailbox slot |
| b_din | input | BW | Port B write data |
| b_fifo_q | input | BW | Queue data offered to port B |
| b_dout | output | BW | Port B registered read data |
| mbx2_full_n | output | 1 | Return slot full, active low, port B clock |
| mbx1_ready_b | output | 1 | Forward slot holds unread mail, port B clock |

## Verification
The bench builds the block with `DW`=36 and `BW`=18. With these widths, port A words must lose their upper half when stored, and slot words must come back to port A zero-extended. Neither effect can appear when the widths are equal. Port A runs at 10 ns and port B at 16 ns, and their rising edges never coincide. This makes the order of cross-domain events well defined, while the phase between the two clocks keeps changing, so the synchronizer latency varies up to its bound.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } port_op_e;

  // Qualify a port strobe: chip select low and enable high, then direction.
  function automatic port_op_e port_op(input logic cs_n, input logic en, input logic is_wr);
    if (cs_n || !en) return OP_IDLE;
    return is_wr ? OP_WRITE : OP_READ;
  endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot import mbx_pkg::*; #(
  parameter int W = 36
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  output logic         full_n,
  output logic [W-1:0] mail,
  input  logic         rclk,
  input  logic         rrst,
  input  logic         rd_req,
  output logic         ready
);
  logic         wr_tog;
  logic         ack_tog;
  logic         wr_tog_rclk;
  logic         ack_tog_wclk;
  logic [W-1:0] mail_q;

  // Writer side: one toggle per accepted word, data held until acknowledged.
  always_ff @(posedge wclk) begin
    if (wrst) begin
      wr_tog <= 1'b0;
      mail_q <= '0;
    end else if (wr_req && full_n) begin
      wr_tog <= ~wr_tog;
      mail_q <= wdata;
    end
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_to_reader (
    .clk(rclk), .rst(rrst), .d(wr_tog), .q(wr_tog_rclk)
  );

  // Reader side: acknowledge by catching up with the synchronized toggle.
  always_ff @(posedge rclk) begin
    if (rrst)                 ack_tog <= 1'b0;
    else if (rd_req && ready) ack_tog <= wr_tog_rclk;
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_to_writer (
    .clk(wclk), .rst(wrst), .d(ack_tog), .q(ack_tog_wclk)
  );

  assign full_n = (wr_tog == ack_tog_wclk);
  assign ready  = (wr_tog_rclk != ack_tog);
  assign mail   = mail_q;
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox import mbx_pkg::*; #(
  parameter int DW = 36,
  parameter int BW = 36
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          a_cs_n,
  input  logic          a_en,
  input  logic          a_wnr,
  input  logic          a_mbx,
  input  logic [DW-1:0] a_din,
  input  logic [DW-1:0] a_fifo_q,
  output logic [DW-1:0] a_dout,
  output logic          mbx1_full_n,
  output logic          mbx2_ready_a,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          b_cs_n,
  input  logic          b_en,
  input  logic          b_rnw,
  input  logic          b_mbx,
  input  logic [BW-1:0] b_din,
  input  logic [BW-1:0] b_fifo_q,
  output logic [BW-1:0] b_dout,
  output logic          mbx2_full_n,
  output logic          mbx1_ready_b
);
  port_op_e      op_a;
  port_op_e      op_b;
  logic          fwd_wr;
  logic          fwd_rd;
  logic          ret_wr;
  logic          ret_rd;
  logic [BW-1:0] fwd_mail;
  logic [BW-1:0] ret_mail;
  logic [DW-1:0] ret_mail_ext;

  assign op_a   = port_op(a_cs_n, a_en, a_wnr);
  assign op_b   = port_op(b_cs_n, b_en, !b_rnw);
  assign fwd_wr = (op_a == OP_WRITE) && a_mbx;
  assign fwd_rd = (op_b == OP_READ)  && b_mbx;
  assign ret_wr = (op_b == OP_WRITE) && b_mbx;
  assign ret_rd = (op_a == OP_READ)  && a_mbx;

  mbx_slot #(.W(BW)) u_fwd (
    .wclk(clk_a), .wrst(rst_a), .wr_req(fwd_wr), .wdata(a_din[BW-1:0]),
    .full_n(mbx1_full_n), .mail(fwd_mail),
    .rclk(clk_b), .rrst(rst_b), .rd_req(fwd_rd), .ready(mbx1_ready_b)
  );

  mbx_slot #(.W(BW)) u_ret (
    .wclk(clk_b), .wrst(rst_b), .wr_req(ret_wr), .wdata(b_din),
    .full_n(mbx2_full_n), .mail(ret_mail),
    .rclk(clk_a), .rrst(rst_a), .rd_req(ret_rd), .ready(mbx2_ready_a)
  );

  always_comb begin
    ret_mail_ext         = '0;
    ret_mail_ext[BW-1:0] = ret_mail;
  end

  always_ff @(posedge clk_a) begin
    if (rst_a) a_dout <= '0;
    else       a_dout <= a_mbx ? ret_mail_ext : a_fifo_q;
  end

  always_ff @(posedge clk_b) begin
    if (rst_b) b_dout <= '0;
    else       b_dout <= b_mbx ? fwd_mail : b_fifo_q;
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DW = 36,
  parameter int BW = 36
) (
  input logic          clk_a,
  input logic          rst_a,
  input logic          a_cs_n,
  input logic          a_en,
  input logic          a_wnr,
  input logic          a_mbx,
  input logic [DW-1:0] a_fifo_q,
  input logic [DW-1:0] a_dout,
  input logic          mbx1_full_n,
  input logic          mbx2_ready_a,
  input logic          clk_b,
  input logic          rst_b,
  input logic          b_cs_n,
  input logic          b_en,
  input logic          b_rnw,
  input logic          b_mbx,
  input logic          mbx2_full_n,
  input logic          mbx1_ready_b,
  input logic [BW-1:0] fwd_mail
);
  p_reset_flag_r1: assert property (@(posedge clk_a) rst_a |=> mbx1_full_n);

  p_write_locks_r2: assert property (@(posedge clk_a) disable iff (rst_a)
    (!a_cs_n && a_en && a_wnr && a_mbx && mbx1_full_n) |=> !mbx1_full_n);

  p_locked_holds_r3: assert property (@(posedge clk_a) disable iff (rst_a)
    !mbx1_full_n |=> $stable(fwd_mail));

  p_read_clears_r4: assert property (@(posedge clk_b) disable iff (rst_b)
    (!b_cs_n && b_en && b_rnw && b_mbx && mbx1_ready_b) |=> !mbx1_ready_b);

  p_ret_write_r5: assert property (@(posedge clk_b) disable iff (rst_b)
    (!b_cs_n && b_en && !b_rnw && b_mbx && mbx2_full_n) |=> !mbx2_full_n);

  p_ret_read_r5: assert property (@(posedge clk_a) disable iff (rst_a)
    (!a_cs_n && a_en && !a_wnr && a_mbx && mbx2_ready_a) |=> !mbx2_ready_a);

  p_gated_idle_r6: assert property (@(posedge clk_a) disable iff (rst_a)
    ((a_cs_n || !a_en) && mbx1_full_n) |=> mbx1_full_n);

  p_queue_path_r7: assert property (@(posedge clk_a) disable iff (rst_a)
    !a_mbx |=> (a_dout == $past(a_fifo_q)));
endmodule

bind dual_mailbox mbx_checker #(.DW(DW), .BW(BW)) i_mbx_checker (
  .clk_a(clk_a), .rst_a(rst_a), .a_cs_n(a_cs_n), .a_en(a_en), .a_wnr(a_wnr),
  .a_mbx(a_mbx), .a_fifo_q(a_fifo_q), .a_dout(a_dout),
  .mbx1_full_n(mbx1_full_n), .mbx2_ready_a(mbx2_ready_a),
  .clk_b(clk_b), .rst_b(rst_b), .b_cs_n(b_cs_n), .b_en(b_en), .b_rnw(b_rnw),
  .b_mbx(b_mbx), .mbx2_full_n(mbx2_full_n), .mbx1_ready_b(mbx1_ready_b),
  .fwd_mail(fwd_mail)
);

// File: tb/test_dual_mailbox.sv
module test_dual_mailbox;
  localparam int DW = 36;
  localparam int BW = 18;

  logic          clk_a = 1'b0, clk_b = 1'b0;
  logic          rst_a = 1'b1, rst_b = 1'b1;
  logic          a_cs_n = 1'b1, a_en = 1'b0, a_wnr = 1'b0, a_mbx = 1'b0;
  logic [DW-1:0] a_din = '0, a_fifo_q = 36'h0_0000_0101;
  logic          b_cs_n = 1'b1, b_en = 1'b0, b_rnw = 1'b1, b_mbx = 1'b0;
  logic [BW-1:0] b_din = '0, b_fifo_q = 18'h0_0202;
  logic [DW-1:0] a_dout;
  logic [BW-1:0] b_dout;
  logic          mbx1_full_n, mbx2_ready_a, mbx2_full_n, mbx1_ready_b;

  int checks = 0;
  int bad    = 0;
  bit run    = 1'b0;

  // behavioural model
  logic [BW-1:0] mail1_m = '0, mail2_m = '0;
  logic          m1_empty = 1'b1, m2_empty = 1'b1;
  logic [DW-1:0] exp_a = '0;
  logic [BW-1:0] exp_b = '0;

  localparam logic [DW-1:0] W1 = 36'hF_1234_5678;
  localparam logic [DW-1:0] W2 = 36'h3_0BAD_CAFE;
  localparam logic [DW-1:0] W3 = 36'hA_5555_9999;
  localparam logic [BW-1:0] V1 = 18'h2_5A5A;
  localparam logic [BW-1:0] V2 = 18'h1_0F0F;

  always #5 clk_a = ~clk_a;
  always #8 clk_b = ~clk_b;

  dual_mailbox #(.DW(DW), .BW(BW)) i_dual_mailbox (
    .clk_a(clk_a), .rst_a(rst_a), .a_cs_n(a_cs_n), .a_en(a_en), .a_wnr(a_wnr),
    .a_mbx(a_mbx), .a_din(a_din), .a_fifo_q(a_fifo_q), .a_dout(a_dout),
    .mbx1_full_n(mbx1_full_n), .mbx2_ready_a(mbx2_ready_a),
    .clk_b(clk_b), .rst_b(rst_b), .b_cs_n(b_cs_n), .b_en(b_en), .b_rnw(b_rnw),
    .b_mbx(b_mbx), .b_din(b_din), .b_fifo_q(b_fifo_q), .b_dout(b_dout),
    .mbx2_full_n(mbx2_full_n), .mbx1_ready_b(mbx1_ready_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  // model updates on each port clock
  always @(posedge clk_a) begin
    if (rst_a) begin
      mail1_m <= '0; m1_empty <= 1'b1; exp_a <= '0;
    end else begin
      if (!a_cs_n && a_en && a_wnr && a_mbx && m1_empty) begin
        mail1_m <= a_din[BW-1:0]; m1_empty <= 1'b0;
      end
      exp_a <= a_mbx ? DW'(mail2_m) : a_fifo_q;
    end
  end

  always @(posedge clk_b) begin
    if (rst_b) begin
      mail2_m <= '0; m2_empty <= 1'b1; exp_b <= '0;
    end else begin
      if (!b_cs_n && b_en && !b_rnw && b_mbx && m2_empty) begin
        mail2_m <= b_din; m2_empty <= 1'b0;
      end
      exp_b <= b_mbx ? mail1_m : b_fifo_q;
    end
  end

  // per-clock comparison of the read outputs (R7)
  always @(negedge clk_a) begin
    if (run && !rst_a) chk(a_dout === exp_a, "R7 a_dout", 64'(a_dout), 64'(exp_a));
    a_fifo_q <= a_fifo_q + 36'h1_0100_0111;
  end

  always @(negedge clk_b) begin
    if (run && !rst_b) chk(b_dout === exp_b, "R7 b_dout", 64'(b_dout), 64'(exp_b));
    b_fifo_q <= b_fifo_q + 18'h0_1203;
  end

  task automatic a_op(input logic wnr, input logic mbx, input logic [DW-1:0] d,
                      input logic cs_n = 1'b0, input logic en = 1'b1);
    @(negedge clk_a);
    a_cs_n = cs_n; a_en = en; a_wnr = wnr; a_mbx = mbx; a_din = d;
    @(negedge clk_a);
    a_cs_n = 1'b1; a_en = 1'b0;
  endtask

  task automatic b_op(input logic rnw, input logic mbx, input logic [BW-1:0] d,
                      input logic cs_n = 1'b0, input logic en = 1'b1);
    @(negedge clk_b);
    b_cs_n = cs_n; b_en = en; b_rnw = rnw; b_mbx = mbx; b_din = d;
    @(negedge clk_b);
    b_cs_n = 1'b1; b_en = 1'b0;
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return mbx1_full_n;
      1: return mbx1_ready_b;
      2: return mbx2_full_n;
      default: return mbx2_ready_a;
    endcase
  endfunction

  // sel: 0 mbx1_full_n (A), 1 mbx1_ready_b (B), 2 mbx2_full_n (B), 3 mbx2_ready_a (A)
  task automatic wait_level(input int sel, input logic want, input string tag);
    logic v;
    int   n;
    v = pick(sel);
    n = 0;
    while (v !== want && n < 4) begin
      if (sel == 0 || sel == 3) @(negedge clk_a);
      else                      @(negedge clk_b);
      n++;
      v = pick(sel);
    end
    chk(v === want, tag, 64'(v), 64'(want));
  endtask

  initial begin
    #1_000_000;
    checks++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk_b);
    run = 1'b1;
    @(negedge clk_a); rst_a = 1'b0;
    @(negedge clk_b); rst_b = 1'b0;
    repeat (3) @(negedge clk_a);

    // R1: idle state after reset
    chk(mbx1_full_n === 1'b1, "R1 mbx1_full_n", 64'(mbx1_full_n), 64'd1);
    chk(mbx2_full_n === 1'b1, "R1 mbx2_full_n", 64'(mbx2_full_n), 64'd1);
    chk(mbx1_ready_b === 1'b0, "R1 mbx1_ready_b", 64'(mbx1_ready_b), 64'd0);
    chk(mbx2_ready_a === 1'b0, "R1 mbx2_ready_a", 64'(mbx2_ready_a), 64'd0);

    // R6: unqualified strobes change nothing
    a_op(1'b1, 1'b1, W2, 1'b1, 1'b1);
    a_op(1'b1, 1'b1, W2, 1'b0, 1'b0);
    b_op(1'b0, 1'b1, V2, 1'b1, 1'b1);
    b_op(1'b0, 1'b1, V2, 1'b0, 1'b0);
    a_op(1'b0, 1'b1, W2); // R9: read of an empty slot
    repeat (6) @(negedge clk_b);
    chk(mbx1_full_n === 1'b1, "R6 mbx1_full_n", 64'(mbx1_full_n), 64'd1);
    chk(mbx1_ready_b === 1'b0, "R6 mbx1_ready_b", 64'(mbx1_ready_b), 64'd0);
    chk(mbx2_full_n === 1'b1, "R6 mbx2_full_n", 64'(mbx2_full_n), 64'd1);
    chk(mbx2_ready_a === 1'b0, "R9 mbx2_ready_a", 64'(mbx2_ready_a), 64'd0);

    // R2: forward write
    a_op(1'b1, 1'b1, W1);
    chk(mbx1_full_n === 1'b0, "R2 mbx1_full_n", 64'(mbx1_full_n), 64'd0);
    wait_level(1, 1'b1, "R8 mbx1_ready_b");
    @(negedge clk_b); b_mbx = 1'b1;
    repeat (2) @(negedge clk_b);
    chk(b_dout === W1[BW-1:0], "R2 b_dout", 64'(b_dout), 64'(W1[BW-1:0]));

    // R3: second write while locked is dropped
    a_op(1'b1, 1'b1, W2);
    repeat (3) @(negedge clk_b);
    chk(b_dout === W1[BW-1:0], "R3 b_dout", 64'(b_dout), 64'(W1[BW-1:0]));
    chk(mbx1_full_n === 1'b0, "R3 mbx1_full_n", 64'(mbx1_full_n), 64'd0);

    // R9: queue read and gated read leave the slot pending
    b_op(1'b1, 1'b0, '0);
    b_op(1'b1, 1'b1, '0, 1'b1, 1'b1);
    repeat (2) @(negedge clk_b);
    chk(mbx1_ready_b === 1'b1, "R9 mbx1_ready_b", 64'(mbx1_ready_b), 64'd1);
    chk(mbx1_full_n === 1'b0, "R9 mbx1_full_n", 64'(mbx1_full_n), 64'd0);

    // R4: mailbox read releases the slot
    b_op(1'b1, 1'b1, '0);
    chk(mbx1_ready_b === 1'b0, "R4 mbx1_ready_b", 64'(mbx1_ready_b), 64'd0);
    wait_level(0, 1'b1, "R4 mbx1_full_n");
    m1_empty <= 1'b1;

    // R5: return slot
    b_op(1'b0, 1'b1, V1);
    chk(mbx2_full_n === 1'b0, "R5 mbx2_full_n", 64'(mbx2_full_n), 64'd0);
    wait_level(3, 1'b1, "R8 mbx2_ready_a");
    @(negedge clk_a); a_mbx = 1'b1;
    repeat (2) @(negedge clk_a);
    chk(a_dout === DW'(V1), "R7 a_dout zero-extended", 64'(a_dout), 64'(DW'(V1)));
    b_op(1'b0, 1'b1, V2);
    repeat (3) @(negedge clk_a);
    chk(a_dout === DW'(V1), "R3 a_dout", 64'(a_dout), 64'(DW'(V1)));
    a_op(1'b0, 1'b1, '0);
    chk(mbx2_ready_a === 1'b0, "R5 mbx2_ready_a", 64'(mbx2_ready_a), 64'd0);
    wait_level(2, 1'b1, "R5 mbx2_full_n");
    m2_empty <= 1'b1;

    // R7: queue data path with select low on both sides
    @(negedge clk_a); a_mbx = 1'b0;
    @(negedge clk_b); b_mbx = 1'b0;
    repeat (6) @(negedge clk_a);

    // R2: slot accepts again after release
    a_op(1'b1, 1'b1, W3);
    chk(mbx1_full_n === 1'b0, "R2 mbx1_full_n again", 64'(mbx1_full_n), 64'd0);
    wait_level(1, 1'b1, "R8 mbx1_ready_b again");
    @(negedge clk_b); b_mbx = 1'b1;
    repeat (2) @(negedge clk_b);
    chk(b_dout === W3[BW-1:0], "R2 b_dout again", 64'(b_dout), 64'(W3[BW-1:0]));

    // R1: reset with pending mail
    @(negedge clk_a); rst_a = 1'b1;
    @(negedge clk_b); rst_b = 1'b1;
    repeat (4) @(negedge clk_b);
    chk(mbx1_full_n === 1'b1, "R1 mbx1_full_n in reset", 64'(mbx1_full_n), 64'd1);
    chk(b_dout === '0, "R1 b_dout in reset", 64'(b_dout), 64'd0);
    @(negedge clk_a); rst_a = 1'b0;
    @(negedge clk_b); rst_b = 1'b0;
    repeat (4) @(negedge clk_b);
    chk(mbx1_full_n === 1'b1, "R1 mbx1_full_n after reset", 64'(mbx1_full_n), 64'd1);
    chk(mbx1_ready_b === 1'b0, "R1 mbx1_ready_b after reset", 64'(mbx1_ready_b), 64'd0);

    repeat (4) @(negedge clk_a);
    finish_run();
  end
endmodule